// File: doc/BRIEF.md
# Hierarchical Sparse Block Walk Sequencer

This block steers a vector datapath through a sparse matrix kept as a tree of square blocks. Each block has side S = 2^LOG_S. At level 0 a block array holds nonzero values. At every higher level a block array holds pointers to the non-empty child arrays one level down. Each pointer is paired with the child's row and column inside the parent block, and a per-child entry count tells how many words the child array holds. The block walks this tree depth-first. It keeps an explicit frame per level instead of recursing, reads the pointer, position and count of each child through a one-outstanding read port, and works out absolute block coordinates as it descends.

For every block it visits, the sequencer issues one command per cycle on a command port: fetch a block array, fetch a count vector, load or store a result segment, load a multiplicand segment, or run the block multiply. Segments are reloaded only when the relevant coordinate moves. A walk is started with the top-level pointer, its count and its level index, and it ends with a one-cycle done pulse. Arithmetic and memory timing belong to other blocks.

Top module: `hsb_walker`

## Requirements
- R1: After reset, and at any time while idle, `cmd_valid`, `mem_req` and `done` are low.
- R2: A block array of N entries at address B is laid out as N pointer or value words at B..B+N-1, N position words at B+N..B+2N-1 and, above level 0, N child counts at B+2N..B+3N-1. On entering a block the sequencer issues fetch-block (op 1, addr B, len N). Above level 0 this is followed by fetch-count (op 2, addr B+2N, len N).
- R3: The children of an upper block are visited in index order, depth-first. For child i the sequencer reads address B+i (pointer), then B+N+i (position), then B+2N+i (count), and only then enters the child.
- R4: A position word carries the in-block column in bits [LOG_S-1:0] and the in-block row in bits [DATA_W/2+LOG_S-1:DATA_W/2]. A child's block coordinate is parent*S + in-block value on each axis, and the top block sits at (0,0).
- R5: At level 0, when the column differs from the previous level-0 block, the sequencer issues store-result (op 4, addr prev_col*S, len S) and then load-result (op 3, addr col*S, len S). The first level-0 block of a walk issues only the load.
- R6: At level 0, load-multiplicand (op 5, addr row*S, len S) is issued for the first level-0 block and otherwise only when the row differs from the previous one.
- R7: Every level-0 block ends with execute (op 6, addr B, len N, its coordinates), issued after any segment commands for that block.
- R8: After the last block, a walk that visited level 0 issues one final store-result for the last column, then raises `done` for exactly one cycle. A walk whose top count is 0 issues no command and only raises `done`.
- R9: At most one memory read is outstanding, and `mem_req` is high for single cycles only.
- R10: `start` is ignored while a walk is in progress.
- R11: A walk whose top level is 0 treats the top array as a single level-0 block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| start_ptr | input | ADDR_W | Address of the top block array |
| start_len | input | LEN_W | Entry count of the top block array |
| start_lvl | input | LVL_W | Level index of the top block |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | ADDR_W | Read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | Command code (1 fetch-block, 2 fetch-count, 3 load-result, 4 store-result, 5 load-multiplicand, 6 execute) |
| cmd_addr | output | ADDR_W | Command base address |
| cmd_len | output | LEN_W | Command word count |
| cmd_row | output | COORD_W | Block row coordinate |
| cmd_col | output | COORD_W | Block column coordinate |
| done | output | 1 | Walk finished, one cycle |

## Verification
The hardest situations to reach are the segment-reuse branches. They need consecutive level-0 blocks that share a column but not a row, and the reverse, and they need these reached through different parents so that coordinates are assembled from pointer words at two depths. The bench builds such trees in its memory model: one two-level tree whose three children step through column-change/row-same and column-same/row-change, and one three-level chain whose nonzero in-block positions exercise the parent*S composition twice. A second start pulse is injected mid-walk to show that it leaves the command stream untouched.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_FETCH_BLK = 3'd1,
      OP_FETCH_CNT = 3'd2,
      OP_LOAD_RES  = 3'd3,
      OP_STORE_RES = 3'd4,
      OP_LOAD_MUL  = 3'd5,
      OP_EXEC      = 3'd6
   } hsb_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENTER,
      ST_CNT,
      ST_NEXT,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_PUSH,
      ST_L0_STORE,
      ST_L0_LOAD,
      ST_L0_MUL,
      ST_L0_EXEC,
      ST_FINAL,
      ST_DONE
   } hsb_state_e;

   typedef enum logic [1:0] {
      RD_PTR = 2'd0,
      RD_POS = 2'd1,
      RD_CNT = 2'd2
   } hsb_rd_e;

endpackage

// File: rtl/hsb_frame_stack.sv
module hsb_frame_stack #(
   parameter int MAX_LVL = 4,
   parameter int ADDR_W  = 16,
   parameter int LEN_W   = 5,
   parameter int COORD_W = 16,
   parameter int LVL_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_en,
   input  logic [LVL_W-1:0]   push_lvl,
   input  logic [ADDR_W-1:0]  push_base,
   input  logic [LEN_W-1:0]   push_len,
   input  logic [COORD_W-1:0] push_row,
   input  logic [COORD_W-1:0] push_col,
   input  logic               bump_en,
   input  logic [LVL_W-1:0]   bump_lvl,
   input  logic [LVL_W-1:0]   rd_lvl,
   output logic [ADDR_W-1:0]  rd_base,
   output logic [LEN_W-1:0]   rd_len,
   output logic [LEN_W-1:0]   rd_idx,
   output logic [COORD_W-1:0] rd_row,
   output logic [COORD_W-1:0] rd_col
);

   logic [ADDR_W-1:0]  base_a [MAX_LVL];
   logic [LEN_W-1:0]   len_a  [MAX_LVL];
   logic [LEN_W-1:0]   idx_a  [MAX_LVL];
   logic [COORD_W-1:0] row_a  [MAX_LVL];
   logic [COORD_W-1:0] col_a  [MAX_LVL];

   for (genvar g = 0; g < MAX_LVL; g++) begin : g_frame
      logic [ADDR_W-1:0]  base_q;
      logic [LEN_W-1:0]   len_q;
      logic [LEN_W-1:0]   idx_q;
      logic [COORD_W-1:0] row_q;
      logic [COORD_W-1:0] col_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            row_q  <= '0;
            col_q  <= '0;
         end else if (push_en && (push_lvl == LVL_W'(g))) begin
            base_q <= push_base;
            len_q  <= push_len;
            idx_q  <= '0;
            row_q  <= push_row;
            col_q  <= push_col;
         end else if (bump_en && (bump_lvl == LVL_W'(g))) begin
            idx_q  <= idx_q + 1'b1;
         end
      end

      assign base_a[g] = base_q;
      assign len_a[g]  = len_q;
      assign idx_a[g]  = idx_q;
      assign row_a[g]  = row_q;
      assign col_a[g]  = col_q;

      // R3: a frame's child index never runs past its entry count
      p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         idx_q <= len_q);
   end

   assign rd_base = base_a[rd_lvl];
   assign rd_len  = len_a[rd_lvl];
   assign rd_idx  = idx_a[rd_lvl];
   assign rd_row  = row_a[rd_lvl];
   assign rd_col  = col_a[rd_lvl];

   // R3: a frame is never reopened and advanced in the same cycle
   p_push_bump_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && bump_en) |-> (push_lvl != bump_lvl));

endmodule

// File: rtl/hsb_coord_calc.sv
module hsb_coord_calc #(
   parameter int COORD_W     = 16,
   parameter int LOG_S       = 2,
   parameter int DATA_W      = 32,
   parameter bit ROW_IN_HIGH = 1'b1
) (
   input  logic [COORD_W-1:0] parent_row,
   input  logic [COORD_W-1:0] parent_col,
   input  logic [DATA_W-1:0]  pos_word,
   output logic [COORD_W-1:0] child_row,
   output logic [COORD_W-1:0] child_col
);

   localparam int HALF = DATA_W / 2;

   logic [LOG_S-1:0] in_row;
   logic [LOG_S-1:0] in_col;

   if (ROW_IN_HIGH) begin : g_row_high
      assign in_row = pos_word[HALF +: LOG_S];
      assign in_col = pos_word[0 +: LOG_S];
   end else begin : g_row_low
      assign in_row = pos_word[0 +: LOG_S];
      assign in_col = pos_word[HALF +: LOG_S];
   end

   assign child_row = {parent_row[COORD_W-LOG_S-1:0], in_row};
   assign child_col = {parent_col[COORD_W-LOG_S-1:0], in_col};

   logic unused_coord_bits;
   assign unused_coord_bits = ^{pos_word, parent_row, parent_col};

endmodule

// File: rtl/hsb_seg_tracker.sv
module hsb_seg_tracker #(
   parameter int COORD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               commit,
   input  logic [COORD_W-1:0] cur_row,
   input  logic [COORD_W-1:0] cur_col,
   output logic               have_prev,
   output logic [COORD_W-1:0] prev_row,
   output logic [COORD_W-1:0] prev_col,
   output logic               col_move,
   output logic               row_move
);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         have_prev <= 1'b0;
         prev_row  <= '0;
         prev_col  <= '0;
      end else if (commit) begin
         have_prev <= 1'b1;
         prev_row  <= cur_row;
         prev_col  <= cur_col;
      end
   end

   assign col_move = !have_prev || (cur_col != prev_col);
   assign row_move = !have_prev || (cur_row != prev_row);

   // R5: once a block is committed the tracker remembers it
   p_commit_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !clear) |=> have_prev);

endmodule

// File: rtl/hsb_walker.sv
module hsb_walker
   import hsb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int LOG_S       = 2,
   parameter int MAX_LVL     = 4,
   parameter int COORD_W     = 16,
   parameter int LEN_W       = 2 * LOG_S + 1,
   parameter bit ROW_IN_HIGH = 1'b1,
   parameter int LVL_W       = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_ptr,
   input  logic [LEN_W-1:0]   start_len,
   input  logic [LVL_W-1:0]   start_lvl,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_rvalid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               cmd_valid,
   output logic [2:0]         cmd_op,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic [LEN_W-1:0]   cmd_len,
   output logic [COORD_W-1:0] cmd_row,
   output logic [COORD_W-1:0] cmd_col,
   output logic               done
);

   localparam int SIDE = 1 << LOG_S;

   if (LOG_S < 1 || 2 * LOG_S > DATA_W / 2) begin : g_bad_side
      $error("hsb_walker: LOG_S out of range for DATA_W");
   end
   if (MAX_LVL < 1) begin : g_bad_depth
      $error("hsb_walker: MAX_LVL must be at least 1");
   end
   if (ADDR_W > DATA_W || LEN_W >= ADDR_W || LEN_W <= LOG_S) begin : g_bad_width
      $error("hsb_walker: ADDR_W, LEN_W and DATA_W do not fit together");
   end
   if (COORD_W <= LOG_S * MAX_LVL - 1) begin : g_bad_coord
      $error("hsb_walker: COORD_W too narrow for MAX_LVL levels");
   end

   hsb_state_e        state_q;
   hsb_rd_e           rd_sel_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [LVL_W-1:0]  top_lvl_q;
   logic [ADDR_W-1:0] ch_ptr_q;
   logic [DATA_W-1:0] ch_pos_q;
   logic [LEN_W-1:0]  ch_len_q;

   logic [ADDR_W-1:0]  fr_base;
   logic [LEN_W-1:0]   fr_len;
   logic [LEN_W-1:0]   fr_idx;
   logic [COORD_W-1:0] fr_row;
   logic [COORD_W-1:0] fr_col;

   logic               push_en;
   logic [LVL_W-1:0]   push_lvl;
   logic [ADDR_W-1:0]  push_base;
   logic [LEN_W-1:0]   push_len;
   logic [COORD_W-1:0] push_row;
   logic [COORD_W-1:0] push_col;
   logic               bump_en;
   logic [COORD_W-1:0] kid_row;
   logic [COORD_W-1:0] kid_col;

   logic               trk_clear;
   logic               trk_commit;
   logic               have_prev;
   logic [COORD_W-1:0] prev_row;
   logic [COORD_W-1:0] prev_col;
   logic               col_move;
   logic               row_move;

   logic               at_top;
   logic               at_leaf;
   logic [ADDR_W-1:0]  len_ext;
   logic [ADDR_W-1:0]  idx_ext;
   logic [ADDR_W-1:0]  cnt_base;
   hsb_op_e            op_d;

   assign at_top   = (lvl_q == top_lvl_q);
   assign at_leaf  = (lvl_q == '0);
   assign len_ext  = ADDR_W'(fr_len);
   assign idx_ext  = ADDR_W'(fr_idx);
   assign cnt_base = fr_base + (len_ext << 1);

   hsb_frame_stack #(
      .MAX_LVL (MAX_LVL),
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .COORD_W (COORD_W),
      .LVL_W   (LVL_W)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_en),
      .push_lvl  (push_lvl),
      .push_base (push_base),
      .push_len  (push_len),
      .push_row  (push_row),
      .push_col  (push_col),
      .bump_en   (bump_en),
      .bump_lvl  (lvl_q),
      .rd_lvl    (lvl_q),
      .rd_base   (fr_base),
      .rd_len    (fr_len),
      .rd_idx    (fr_idx),
      .rd_row    (fr_row),
      .rd_col    (fr_col)
   );

   hsb_coord_calc #(
      .COORD_W     (COORD_W),
      .LOG_S       (LOG_S),
      .DATA_W      (DATA_W),
      .ROW_IN_HIGH (ROW_IN_HIGH)
   ) u_coord (
      .parent_row (fr_row),
      .parent_col (fr_col),
      .pos_word   (ch_pos_q),
      .child_row  (kid_row),
      .child_col  (kid_col)
   );

   hsb_seg_tracker #(
      .COORD_W (COORD_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (trk_clear),
      .commit    (trk_commit),
      .cur_row   (fr_row),
      .cur_col   (fr_col),
      .have_prev (have_prev),
      .prev_row  (prev_row),
      .prev_col  (prev_col),
      .col_move  (col_move),
      .row_move  (row_move)
   );

   // frame writes: the top frame on start, a child frame on descent
   always_comb begin
      push_en   = 1'b0;
      push_lvl  = lvl_q - 1'b1;
      push_base = ch_ptr_q;
      push_len  = ch_len_q;
      push_row  = kid_row;
      push_col  = kid_col;
      bump_en   = (state_q == ST_PUSH);
      trk_clear = 1'b0;
      if (state_q == ST_IDLE) begin
         push_en   = start;
         push_lvl  = start_lvl;
         push_base = start_ptr;
         push_len  = start_len;
         push_row  = '0;
         push_col  = '0;
         trk_clear = start;
      end else if (state_q == ST_PUSH) begin
         push_en   = 1'b1;
      end
   end

   assign trk_commit = (state_q == ST_L0_EXEC);

   // memory read port
   always_comb begin
      mem_req  = (state_q == ST_RD_ISSUE);
      mem_addr = '0;
      if (state_q == ST_RD_ISSUE) begin
         case (rd_sel_q)
            RD_PTR:  mem_addr = fr_base + idx_ext;
            RD_POS:  mem_addr = fr_base + len_ext + idx_ext;
            default: mem_addr = cnt_base + idx_ext;
         endcase
      end
   end

   // command port
   always_comb begin
      op_d     = OP_NONE;
      cmd_addr = '0;
      cmd_len  = '0;
      cmd_row  = fr_row;
      cmd_col  = fr_col;
      case (state_q)
         ST_ENTER: begin
            op_d     = OP_FETCH_BLK;
            cmd_addr = fr_base;
            cmd_len  = fr_len;
         end
         ST_CNT: begin
            op_d     = OP_FETCH_CNT;
            cmd_addr = cnt_base;
            cmd_len  = fr_len;
         end
         ST_L0_STORE, ST_FINAL: begin
            if (have_prev && (col_move || state_q == ST_FINAL)) begin
               op_d = OP_STORE_RES;
            end
            cmd_addr = ADDR_W'(prev_col) << LOG_S;
            cmd_len  = LEN_W'(SIDE);
            cmd_row  = prev_row;
            cmd_col  = prev_col;
         end
         ST_L0_LOAD: begin
            if (col_move) op_d = OP_LOAD_RES;
            cmd_addr = ADDR_W'(fr_col) << LOG_S;
            cmd_len  = LEN_W'(SIDE);
         end
         ST_L0_MUL: begin
            if (row_move) op_d = OP_LOAD_MUL;
            cmd_addr = ADDR_W'(fr_row) << LOG_S;
            cmd_len  = LEN_W'(SIDE);
         end
         ST_L0_EXEC: begin
            op_d     = OP_EXEC;
            cmd_addr = fr_base;
            cmd_len  = fr_len;
         end
         default: ;
      endcase
   end

   assign cmd_valid = (op_d != OP_NONE);
   assign cmd_op    = op_d;
   assign done      = (state_q == ST_DONE);

   // walk control
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rd_sel_q  <= RD_PTR;
         lvl_q     <= '0;
         top_lvl_q <= '0;
         ch_ptr_q  <= '0;
         ch_pos_q  <= '0;
         ch_len_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  lvl_q     <= start_lvl;
                  top_lvl_q <= start_lvl;
                  state_q   <= (start_len == '0) ? ST_DONE : ST_ENTER;
               end
            end
            ST_ENTER:  state_q <= at_leaf ? ST_L0_STORE : ST_CNT;
            ST_CNT:    state_q <= ST_NEXT;
            ST_NEXT: begin
               if (fr_idx == fr_len) begin
                  if (at_top) begin
                     state_q <= ST_FINAL;
                  end else begin
                     lvl_q   <= lvl_q + 1'b1;
                  end
               end else begin
                  rd_sel_q <= RD_PTR;
                  state_q  <= ST_RD_ISSUE;
               end
            end
            ST_RD_ISSUE: state_q <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (mem_rvalid) begin
                  case (rd_sel_q)
                     RD_PTR: begin
                        ch_ptr_q <= mem_rdata[ADDR_W-1:0];
                        rd_sel_q <= RD_POS;
                        state_q  <= ST_RD_ISSUE;
                     end
                     RD_POS: begin
                        ch_pos_q <= mem_rdata;
                        rd_sel_q <= RD_CNT;
                        state_q  <= ST_RD_ISSUE;
                     end
                     default: begin
                        ch_len_q <= mem_rdata[LEN_W-1:0];
                        state_q  <= ST_PUSH;
                     end
                  endcase
               end
            end
            ST_PUSH: begin
               lvl_q   <= lvl_q - 1'b1;
               state_q <= ST_ENTER;
            end
            ST_L0_STORE: state_q <= ST_L0_LOAD;
            ST_L0_LOAD:  state_q <= ST_L0_MUL;
            ST_L0_MUL:   state_q <= ST_L0_EXEC;
            ST_L0_EXEC: begin
               if (at_top) begin
                  state_q <= ST_FINAL;
               end else begin
                  lvl_q   <= lvl_q + 1'b1;
                  state_q <= ST_NEXT;
               end
            end
            ST_FINAL: state_q <= ST_DONE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   logic unused_rdata_bits;
   assign unused_rdata_bits = ^mem_rdata;

   // R1: an idle sequencer drives nothing
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (!cmd_valid && !mem_req && !done));

   // R9: requests are single-cycle, never back to back
   p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R5: a result load after the first block follows a result store
   p_store_before_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_LOAD_RES && have_prev)
         |-> $past(cmd_valid && cmd_op == OP_STORE_RES));

   // R6: a multiplicand load only when the row has moved
   p_mul_on_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_LOAD_MUL) |-> (!have_prev || cmd_row != prev_row));

   // R7: execute is only issued on level 0
   p_exec_leaf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_EXEC) |-> at_leaf);

   // R8: done lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/hsb_walker_tb.sv
module hsb_walker_tb;

   localparam int ADDR_W  = 16;
   localparam int DATA_W  = 32;
   localparam int LOG_S   = 2;
   localparam int MAX_LVL = 4;
   localparam int COORD_W = 16;
   localparam int LEN_W   = 2 * LOG_S + 1;
   localparam int LVL_W   = 2;

   // expected commands: {walk id, op, addr, len, row, col}
   localparam int EXP_N = 28;
   localparam int EXP [EXP_N][6] = '{
      '{0, 1, 16, 3, 0, 0}, '{0, 2, 22, 3, 0, 0},
      '{0, 1, 64, 2, 0, 0}, '{0, 3,  0, 4, 0, 0}, '{0, 5,  0, 4, 0, 0}, '{0, 6, 64, 2, 0, 0},
      '{0, 1, 80, 1, 0, 2}, '{0, 4,  0, 4, 0, 0}, '{0, 3,  8, 4, 0, 2}, '{0, 6, 80, 1, 0, 2},
      '{0, 1, 96, 3, 1, 2}, '{0, 5,  4, 4, 1, 2}, '{0, 6, 96, 3, 1, 2}, '{0, 4,  8, 4, 1, 2},
      '{1, 1, 100, 5, 0, 0}, '{1, 3, 0, 4, 0, 0}, '{1, 5, 0, 4, 0, 0}, '{1, 6, 100, 5, 0, 0},
      '{1, 4, 0, 4, 0, 0},
      '{2, 1, 32, 1, 0, 0}, '{2, 2, 34, 1, 0, 0}, '{2, 1, 48, 1, 1, 3}, '{2, 2, 50, 1, 1, 3},
      '{2, 1, 120, 2, 6, 13}, '{2, 3, 52, 4, 6, 13}, '{2, 5, 24, 4, 6, 13},
      '{2, 6, 120, 2, 6, 13}, '{2, 4, 52, 4, 6, 13}
   };
   localparam int RD_EXP [9] = '{16, 19, 22, 17, 20, 23, 18, 21, 24};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [ADDR_W-1:0]  start_ptr = '0;
   logic [LEN_W-1:0]   start_len = '0;
   logic [LVL_W-1:0]   start_lvl = '0;
   logic               mem_req;
   logic [ADDR_W-1:0]  mem_addr;
   logic               mem_rvalid = 1'b0;
   logic [DATA_W-1:0]  mem_rdata = '0;
   logic               cmd_valid;
   logic [2:0]         cmd_op;
   logic [ADDR_W-1:0]  cmd_addr;
   logic [LEN_W-1:0]   cmd_len;
   logic [COORD_W-1:0] cmd_row;
   logic [COORD_W-1:0] cmd_col;
   logic               done;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   hsb_walker #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LOG_S (LOG_S),
      .MAX_LVL (MAX_LVL), .COORD_W (COORD_W), .LEN_W (LEN_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .start_ptr (start_ptr),
      .start_len (start_len), .start_lvl (start_lvl), .mem_req (mem_req),
      .mem_addr (mem_addr), .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
      .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_addr (cmd_addr),
      .cmd_len (cmd_len), .cmd_row (cmd_row), .cmd_col (cmd_col), .done (done)
   );

   // memory model: two-cycle read latency, one response per request
   logic [DATA_W-1:0] mem [256];
   int pend_cnt = 0;
   int pend_addr = 0;
   int overlap = 0;
   int rd_n = 0;
   int rd_log [32];

   always @(negedge clk) begin
      if (!rst_n) begin
         pend_cnt   = 0;
         mem_rvalid = 1'b0;
      end else begin
         mem_rvalid = 1'b0;
         if (pend_cnt != 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem[pend_addr];
            end
         end
         if (mem_req) begin
            if (pend_cnt != 0) overlap = overlap + 1;
            pend_addr = int'(mem_addr[7:0]);
            pend_cnt  = 2;
            if (rd_n < 32) rd_log[rd_n] = int'(mem_addr);
            rd_n = rd_n + 1;
         end
      end
   end

   // command monitor
   logic logging = 1'b0;
   int log_n = 0;
   int log_f [64][5];

   always @(negedge clk) begin
      if (logging && cmd_valid) begin
         if (log_n < 64) begin
            log_f[log_n][0] = int'(cmd_op);
            log_f[log_n][1] = int'(cmd_addr);
            log_f[log_n][2] = int'(cmd_len);
            log_f[log_n][3] = int'(cmd_row);
            log_f[log_n][4] = int'(cmd_col);
         end
         log_n = log_n + 1;
      end
   end

   function automatic string req_of(input int op);
      case (op)
         1, 2:    return "R2";
         3, 4:    return "R5";
         5:       return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic put_pos(input int addr, input int row, input int col);
      mem[addr] = (DATA_W'(row) << (DATA_W / 2)) | DATA_W'(col);
   endtask

   task automatic walk(input int ptr, input int len, input int lvl,
                       input bit inject, output bit finished);
      int cyc;
      log_n = 0;
      rd_n = 0;
      logging = 1'b1;
      finished = 1'b0;
      @(negedge clk);
      start     = 1'b1;
      start_ptr = ADDR_W'(ptr);
      start_len = LEN_W'(len);
      start_lvl = LVL_W'(lvl);
      for (cyc = 0; cyc < 2000; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         if (done) begin
            finished = 1'b1;
            break;
         end
         if (inject && cyc == 12) begin
            // R10: a second start during the walk must change nothing
            start     = 1'b1;
            start_ptr = ADDR_W'(200);
            start_len = LEN_W'(7);
            start_lvl = LVL_W'(0);
         end
      end
      start = 1'b0;
      @(negedge clk);
      logging = 1'b0;
   endtask

   task automatic compare(input int id, input string tag);
      int k = 0;
      for (int e = 0; e < EXP_N; e++) begin
         if (EXP[e][0] == id) begin
            if (k < log_n && k < 64) begin
               for (int f = 0; f < 5; f++) begin
                  check(log_f[k][f] == EXP[e][f + 1],
                        (f >= 3) ? "R4" : req_of(EXP[e][1]),
                        $sformatf("%s cmd %0d field %0d", tag, k, f),
                        log_f[k][f], EXP[e][f + 1]);
               end
            end
            k++;
         end
      end
      check(log_n == k, "R8", {tag, " command count"}, log_n, k);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      bit fin;
      for (int a = 0; a < 256; a++) mem[a] = '0;
      // two-level tree: top at 16 with three children
      mem[16] = 64; mem[17] = 80; mem[18] = 96;
      put_pos(19, 0, 0); put_pos(20, 0, 2); put_pos(21, 1, 2);
      mem[22] = 2; mem[23] = 1; mem[24] = 3;
      // three-level chain: 32 -> 48 -> 120
      mem[32] = 48; put_pos(33, 1, 3); mem[34] = 1;
      mem[48] = 120; put_pos(49, 2, 1); mem[50] = 2;

      repeat (4) @(negedge clk);
      // R1: reset state
      check(!cmd_valid, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
      check(!mem_req, "R1", "mem_req in reset", int'(mem_req), 0);
      check(!done, "R1", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!cmd_valid && !mem_req && !done, "R1", "idle outputs", int'(cmd_valid), 0);

      // table walk: two-level tree with a start injected mid-walk (R10)
      walk(16, 3, 1, 1'b1, fin);
      check(fin, "R8", "two-level walk finished", int'(fin), 1);
      compare(0, "two-level");
      for (int r = 0; r < 9; r++) begin
         check(r < rd_n && rd_log[r] == RD_EXP[r], "R3",
               $sformatf("read %0d address", r), rd_log[r], RD_EXP[r]);
      end
      check(rd_n == 9, "R3", "read count", rd_n, 9);
      check(!cmd_valid && !done, "R10", "quiet after injected start", int'(cmd_valid), 0);

      // R11: top array is itself a level-0 block
      walk(100, 5, 0, 1'b0, fin);
      check(fin, "R11", "level-0 top finished", int'(fin), 1);
      compare(1, "R11 leaf-top");
      check(rd_n == 0, "R11", "no reads for leaf top", rd_n, 0);

      // R4: three-level coordinate composition
      walk(32, 1, 2, 1'b0, fin);
      check(fin, "R8", "three-level walk finished", int'(fin), 1);
      compare(2, "R4 three-level");

      // R8: empty top issues nothing and still pulses done
      walk(16, 0, 1, 1'b0, fin);
      check(fin, "R8", "empty walk done", int'(fin), 1);
      check(log_n == 0, "R8", "empty walk commands", log_n, 0);

      // R9: no overlapping reads anywhere
      check(overlap == 0, "R9", "overlapping requests", overlap, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule